// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates interrupt requests for a small processor core and tracks how deeply handlers are nested. A rising edge on a request line latches a pending bit. Each line has its own programmable priority, where a smaller number means more urgent. Every cycle the controller finds the most urgent request that is both pending and enabled. It tells the core to preempt only when that request is strictly more urgent than the level the core is running at, and only when the mask registers allow it.

Enable bits have two bus addresses. One address sets the enable bits that are written as one, and the other clears them. A single write therefore never overwrites enable changes made by other software. A threshold register and two global mask bits can hold interrupts back while their pending bits remain latched.

The core acknowledges a preemption to enter a handler and signals a return when the handler finishes. The controller keeps an internal stack of active levels, so handlers can nest and then unwind in order.

Top module: `prio_intc`

## Requirements
- R1: After reset, enables, pending bits, active bits, priorities, the threshold and both mask bits are zero. `irq_preempt` is low and `exec_level` equals 2**PRIO_W (8 by default), the idle level.
- R2: A write to byte address 0x00 sets every enable bit whose data bit is one and leaves all other enable bits unchanged. A read of 0x00 or 0x04 returns the enable bits.
- R3: A write to byte address 0x04 clears every enable bit whose data bit is one and leaves all other enable bits unchanged.
- R4: A rising edge on `irq_req[i]` sets pending bit i on the clock edge where the high level is first sampled. This happens even when line i is disabled, and a disabled line never causes preemption. A read of 0x08 returns the pending bits, and a write of ones to 0x08 clears them.
- R5: The priority of line i is read and written at byte address 0x40+4*i, using the low PRIO_W bits. Among the pending and enabled lines, the winner has the smallest priority value. Ties go to the lowest line number, and `irq_id` shows the winner while `irq_preempt` is high.
- R6: `irq_preempt` is high only when the winner's priority is strictly below `exec_level`. A winner of equal or lower urgency stays pending and does not preempt.
- R7: An `irq_ack` while `irq_preempt` is high clears the winner's pending bit and sets its active bit (read at 0x0C) on that clock edge. On the same edge `exec_level` becomes the winner's priority, so a more urgent request can nest on top of it.
- R8: `irq_ret` removes the most recent level. On the next edge `exec_level` returns to the previous level (or to idle), and the returning line's active bit clears.
- R9: The threshold at byte address 0x14 (low PRIO_W bits), when nonzero, blocks every winner whose priority is not below it. A value of zero applies no threshold.
- R10: Byte address 0x10 holds two mask bits. Bit 0 blocks all preemption, and bit 1 also blocks all preemption. Clearing them releases the pending winner.
- R11: A new request edge on a line that is already active sets its pending bit again. That request preempts once the handler has returned and the level allows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_req | input | NUM_IRQ | Interrupt request lines, edge sensitive |
| irq_preempt | output | 1 | Preemption request to the core |
| irq_id | output | ID_W | Number of the winning line |
| irq_ack | input | 1 | Core accepts the preemption |
| irq_ret | input | 1 | Core returns from the current handler |
| exec_level | output | PRIO_W+1 | Current execution level; 2**PRIO_W when idle |

## Verification
Register writes, request edges, acknowledges and returns each take effect on the single clock edge that samples them. `irq_preempt`, `irq_id`, `exec_level` and `bus_rdata` are combinational views of that registered state, so each result is due one edge after its stimulus. The bench applies every stimulus on a falling edge and samples one falling edge later, plus a 1 ns settle, when no edge is in flight. Masked, equal-level and re-requested cases are checked in the cycle right after the stimulus and again after the event that releases them.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // word indices (byte address / 4) of the register map
   localparam int REG_EN_SET    = 0;
   localparam int REG_EN_CLR    = 1;
   localparam int REG_PENDING   = 2;
   localparam int REG_ACTIVE    = 3;
   localparam int REG_MASK      = 4;
   localparam int REG_THRESHOLD = 5;
   localparam int REG_PRIO_BASE = 16;
   localparam int BUS_W         = 32;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_IRQ = 8,
   parameter int PRIO_W  = 3,
   parameter int ADDR_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [BUS_W-1:0]          bus_wdata,
   output logic [NUM_IRQ-1:0]        enable,
   output logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
   output logic                      mask_all,
   output logic                      mask_hard,
   output logic [PRIO_W-1:0]         threshold
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              unused_addr;
   assign word        = bus_addr[ADDR_W-1:2];
   assign unused_addr = ^bus_addr[1:0];

   logic [NUM_IRQ-1:0] set_bits, clr_bits;
   assign set_bits = (bus_wr && word == WORD_W'(REG_EN_SET)) ? bus_wdata[NUM_IRQ-1:0] : '0;
   assign clr_bits = (bus_wr && word == WORD_W'(REG_EN_CLR)) ? bus_wdata[NUM_IRQ-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable    <= '0;
         mask_all  <= 1'b0;
         mask_hard <= 1'b0;
         threshold <= '0;
      end else begin
         enable <= (enable | set_bits) & ~clr_bits;
         if (bus_wr && word == WORD_W'(REG_MASK)) begin
            mask_all  <= bus_wdata[0];
            mask_hard <= bus_wdata[1];
         end
         if (bus_wr && word == WORD_W'(REG_THRESHOLD))
            threshold <= bus_wdata[PRIO_W-1:0];
      end
   end

   // one priority register per line
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
      logic [PRIO_W-1:0] prio_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            prio_q <= '0;
         else if (bus_wr && word == WORD_W'(REG_PRIO_BASE + g))
            prio_q <= bus_wdata[PRIO_W-1:0];
      end
      assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
   parameter int NUM_IRQ = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] sw_clear,
   input  logic [NUM_IRQ-1:0] ack_clear,
   output logic [NUM_IRQ-1:0] pending
);
   logic [NUM_IRQ-1:0] req_q, rise;
   assign rise = irq_req & ~req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= '0;
         pending <= '0;
      end else begin
         req_q   <= irq_req;
         // a fresh edge wins over a clear in the same cycle
         pending <= (pending & ~sw_clear & ~ack_clear) | rise;
      end
   end

   a_r4_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((pending & $past(rise)) == $past(rise)));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int NUM_IRQ = 8,
   parameter int PRIO_W  = 3,
   localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic [NUM_IRQ-1:0]        cand,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
   output logic                      win_valid,
   output logic [ID_W-1:0]           win_id,
   output logic [PRIO_W-1:0]         win_prio
);
   always_comb begin
      win_valid = 1'b0;
      win_id    = '0;
      win_prio  = '1;
      // strict compare keeps the lowest index on a tie
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
            win_valid = 1'b1;
            win_id    = ID_W'(i);
            win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/intc_stack.sv
module intc_stack #(
   parameter int ID_W  = 3,
   parameter int LVL_W = 4,
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ID_W-1:0]  push_id,
   input  logic [LVL_W-1:0] push_lvl,
   input  logic             pop,
   output logic [ID_W-1:0]  top_id,
   output logic [LVL_W-1:0] top_lvl,
   output logic             empty,
   output logic             full
);
   localparam logic [LVL_W-1:0] IDLE = {1'b1, {(LVL_W-1){1'b0}}};

   logic [ID_W-1:0]  id_q  [DEPTH];
   logic [LVL_W-1:0] lvl_q [DEPTH];
   logic [CNT_W-1:0] count_q;
   logic [IDX_W-1:0] top_idx, wr_idx;

   assign empty   = (count_q == '0);
   assign full    = (count_q == CNT_W'(DEPTH));
   assign top_idx = IDX_W'(count_q - CNT_W'(1));
   assign wr_idx  = IDX_W'(count_q);
   assign top_id  = empty ? '0 : id_q[top_idx];
   assign top_lvl = empty ? IDLE : lvl_q[top_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            id_q[i]  <= '0;
            lvl_q[i] <= '0;
         end
      end else if (pop && !empty) begin
         count_q <= count_q - CNT_W'(1);
      end else if (push && !full) begin
         id_q[wr_idx]  <= push_id;
         lvl_q[wr_idx] <= push_lvl;
         count_q       <= count_q + CNT_W'(1);
      end
   end

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r8_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty) |=> (count_q == $past(count_q) - CNT_W'(1)));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int NUM_IRQ     = 8,
   parameter int PRIO_W      = 3,
   parameter int STACK_DEPTH = 8,
   parameter int ADDR_W      = 8,
   localparam int ID_W       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
   localparam int LVL_W      = PRIO_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic               irq_preempt,
   output logic [ID_W-1:0]    irq_id,
   input  logic               irq_ack,
   input  logic               irq_ret,
   output logic [LVL_W-1:0]   exec_level
);
   localparam int WORD_W = ADDR_W - 2;

   if (NUM_IRQ < 1 || NUM_IRQ > BUS_W) begin : g_bad_num
      $error("NUM_IRQ must be 1..32");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must be 1..8");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("STACK_DEPTH must be positive");
   end
   if (REG_PRIO_BASE + NUM_IRQ > (1 << WORD_W)) begin : g_bad_addr
      $error("ADDR_W too small for the priority block");
   end

   logic [NUM_IRQ-1:0]        enable, pending, active;
   logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
   logic                      mask_all, mask_hard;
   logic [PRIO_W-1:0]         threshold;

   intc_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .enable(enable), .prio_flat(prio_flat),
      .mask_all(mask_all), .mask_hard(mask_hard), .threshold(threshold));

   logic [WORD_W-1:0]  word;
   logic [NUM_IRQ-1:0] sw_clear, ack_clear;
   logic               do_ack, do_ret;
   assign word     = bus_addr[ADDR_W-1:2];
   assign sw_clear = (bus_wr && word == WORD_W'(REG_PENDING)) ? bus_wdata[NUM_IRQ-1:0] : '0;

   intc_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_clear(sw_clear),
      .ack_clear(ack_clear), .pending(pending));

   logic              win_valid;
   logic [ID_W-1:0]   win_id;
   logic [PRIO_W-1:0] win_prio;

   intc_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
      .cand(pending & enable), .prio_flat(prio_flat),
      .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio));

   logic             stk_empty, stk_full;
   logic [ID_W-1:0]  top_id;

   intc_stack #(.ID_W(ID_W), .LVL_W(LVL_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(do_ack), .push_id(win_id),
      .push_lvl({1'b0, win_prio}), .pop(do_ret), .top_id(top_id),
      .top_lvl(exec_level), .empty(stk_empty), .full(stk_full));

   // effective level: running level, tightened by a nonzero threshold
   logic [LVL_W-1:0] eff_level;
   always_comb begin
      eff_level = exec_level;
      if (threshold != '0 && {1'b0, threshold} < eff_level)
         eff_level = {1'b0, threshold};
   end

   assign irq_preempt = win_valid && !mask_all && !mask_hard && !stk_full
                        && ({1'b0, win_prio} < eff_level);
   assign irq_id      = win_id;

   // a return takes precedence over an acknowledge in the same cycle
   assign do_ret    = irq_ret && !stk_empty;
   assign do_ack    = irq_ack && irq_preempt && !irq_ret;
   assign ack_clear = do_ack ? (NUM_IRQ'(1) << win_id) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         active <= '0;
      else if (do_ret)
         active[top_id] <= 1'b0;
      else if (do_ack)
         active[win_id] <= 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      case (int'(word))
         REG_EN_SET, REG_EN_CLR: bus_rdata[NUM_IRQ-1:0] = enable;
         REG_PENDING:            bus_rdata[NUM_IRQ-1:0] = pending;
         REG_ACTIVE:             bus_rdata[NUM_IRQ-1:0] = active;
         REG_MASK:               bus_rdata[1:0]         = {mask_hard, mask_all};
         REG_THRESHOLD:          bus_rdata[PRIO_W-1:0]  = threshold;
         default: begin
            for (int i = 0; i < NUM_IRQ; i++)
               if (int'(word) == REG_PRIO_BASE + i)
                  bus_rdata[PRIO_W-1:0] = prio_flat[i*PRIO_W +: PRIO_W];
         end
      endcase
   end

   logic [PRIO_W-1:0] id_prio;
   assign id_prio = prio_flat[int'(irq_id)*PRIO_W +: PRIO_W];

   a_r5_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
      irq_preempt |-> (pending[irq_id] && enable[irq_id]));
   a_r6_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
      irq_preempt |-> ({1'b0, id_prio} < exec_level));
   a_r9_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_preempt && threshold != '0) |-> (id_prio < threshold));
   a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_all || mask_hard) |-> !irq_preempt);
   a_r7_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
      do_ack |=> (active[$past(irq_id)] && exec_level == {1'b0, $past(id_prio)}));
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] irq_req = '0;
   logic        irq_preempt;
   logic [2:0]  irq_id;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic [3:0]  exec_level;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   prio_intc uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
      .irq_preempt(irq_preempt), .irq_id(irq_id), .irq_ack(irq_ack),
      .irq_ret(irq_ret), .exec_level(exec_level));

   localparam logic [7:0] A_EN_SET = 8'h00, A_EN_CLR = 8'h04, A_PEND = 8'h08,
                          A_ACT = 8'h0C, A_MASK = 8'h10, A_THR = 8'h14;

   // priorities of lines 0..7
   localparam int PRIO [8] = '{3, 1, 5, 1, 7, 0, 2, 4};

   // {request pulse, enable mask, expect preempt, expected id}
   localparam logic [19:0] VEC [10] = '{
      {8'h01, 8'hFF, 1'b1, 3'd0},
      {8'h0A, 8'hFF, 1'b1, 3'd1},
      {8'h0A, 8'hF5, 1'b0, 3'd0},
      {8'hFF, 8'hFF, 1'b1, 3'd5},
      {8'hFF, 8'hDF, 1'b1, 3'd1},
      {8'h91, 8'hFF, 1'b1, 3'd0},
      {8'h90, 8'hFF, 1'b1, 3'd7},
      {8'h00, 8'hFF, 1'b0, 3'd0},
      {8'h44, 8'h44, 1'b1, 3'd6},
      {8'h14, 8'h10, 1'b1, 3'd4}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(input logic [7:0] a, input int exp, input string tag);
      bus_addr = a;
      #1;
      check(tag, int'(bus_rdata), exp);
   endtask

   task automatic pulse(input logic [N-1:0] m);
      @(negedge clk); irq_req = m;
      @(negedge clk); irq_req = '0;
      #1;
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      #1;
   endtask

   task automatic ret();
      @(negedge clk); irq_ret = 1'b1;
      @(negedge clk); irq_ret = 1'b0;
      #1;
   endtask

   task automatic expect_pre(input string tag, input int pre, input int id);
      check({tag, " preempt"}, int'(irq_preempt), pre);
      if (pre != 0) check({tag, " id"}, int'(irq_id), id);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 preempt", int'(irq_preempt), 0);
      check("R1 level", int'(exec_level), 8);
      rd_check(A_EN_SET, 0, "R1 enables");
      rd_check(A_PEND, 0, "R1 pending");
      rd_check(8'h40, 0, "R1 prio0");

      // R2 / R3 set and clear addresses leave other bits alone
      wr(A_EN_SET, 32'h03);
      wr(A_EN_SET, 32'h10);
      rd_check(A_EN_SET, 32'h13, "R2 set keeps bits");
      wr(A_EN_CLR, 32'h01);
      rd_check(A_EN_CLR, 32'h12, "R3 clear keeps bits");

      // R5 priorities
      for (int i = 0; i < N; i++) wr(8'(8'h40 + 4*i), 32'(PRIO[i]));
      rd_check(8'h54, 0, "R5 prio5 readback");
      rd_check(8'h50, 7, "R5 prio4 readback");

      // R4 disabled line latches but does not preempt
      wr(A_EN_CLR, 32'hFF);
      pulse(8'h04);
      rd_check(A_PEND, 32'h04, "R4 pending latched");
      expect_pre("R4 disabled", 0, 0);
      wr(A_PEND, 32'h04);
      rd_check(A_PEND, 0, "R4 pending cleared");

      // R5 arbitration table
      for (int v = 0; v < 10; v++) begin
         wr(A_PEND, 32'hFF);
         wr(A_EN_CLR, 32'hFF);
         wr(A_EN_SET, 32'(VEC[v][11:4]));
         pulse(VEC[v][19:12]);
         expect_pre($sformatf("R5 vec%0d", v), int'(VEC[v][3]), int'(VEC[v][2:0]));
      end

      // R6 R7 R8 R11 nesting
      wr(A_PEND, 32'hFF);
      wr(A_EN_SET, 32'hFF);
      pulse(8'h40);
      expect_pre("R6 idle take", 1, 6);
      ack();
      check("R7 level after ack", int'(exec_level), 2);
      rd_check(A_ACT, 32'h40, "R7 active");
      rd_check(A_PEND, 0, "R7 pending cleared");
      pulse(8'h40);
      expect_pre("R11 same line active", 0, 0);
      rd_check(A_PEND, 32'h40, "R11 re-pended");
      pulse(8'h02);
      expect_pre("R7 nest", 1, 1);
      ack();
      check("R7 nested level", int'(exec_level), 1);
      pulse(8'h08);
      expect_pre("R6 equal level", 0, 0);
      ret();
      check("R8 level restored", int'(exec_level), 2);
      rd_check(A_ACT, 32'h40, "R8 active cleared");
      expect_pre("R6 released after ret", 1, 3);
      ack();
      rd_check(A_ACT, 32'h48, "R7 active two");
      ret();
      expect_pre("R11 held at equal", 0, 0);
      ret();
      check("R8 idle level", int'(exec_level), 8);
      rd_check(A_ACT, 0, "R8 none active");
      expect_pre("R11 taken after ret", 1, 6);
      ack();
      ret();

      // R9 threshold
      pulse(8'h01);
      expect_pre("R9 before", 1, 0);
      wr(A_THR, 32'd3);
      expect_pre("R9 equal blocked", 0, 0);
      wr(A_THR, 32'd4);
      expect_pre("R9 below passes", 1, 0);
      wr(A_THR, 32'd0);
      expect_pre("R9 zero off", 1, 0);

      // R10 masks
      wr(A_MASK, 32'h1);
      expect_pre("R10 bit0", 0, 0);
      wr(A_MASK, 32'h2);
      expect_pre("R10 bit1", 0, 0);
      wr(A_MASK, 32'h0);
      expect_pre("R10 released", 1, 0);
      ack();
      ret();
      check("R8 final level", int'(exec_level), 8);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule